// File: doc/BRIEF.md
# VGA Text-Mode Timing Generator

This block produces the raster timing for a 640x480, 60 Hz display whose picture is built from character cells eight pixels wide. It runs on a clock of one tick per cell, so one scanline is 100 ticks (800 pixels) and one frame is 525 lines. It drives horizontal and vertical sync, the current cell column, the current scanline and a single display-enable flag. A character fetch and pixel shifter elsewhere uses these to pick the cell to draw and to blank the picture.

The scanline position is kept as an 8-bit counter plus a phase state. The counter starts at zero in each of three phases, so it never needs more than eight bits. In the first phase the counter alone gives the line number. In the second phase the phase state acts as line bit 8. In the third phase, the vertical blanking interval, the counter gives the offset from line 480. Every wrap, phase change, sync edge and enable edge is decided from the count one step early and held in a register, so all outputs come straight from flops. The scanline moves on at the same clock edge where horizontal sync turns active.

Top module: `vga_text_timing`

## Requirements
- R1: While reset is held, and in the first cycle after it, col = 0, line = 0, de = 0, and hsync and vsync are at their inactive level (high with the default active-low polarity).
- R2: col rises by one on every clock from 0 to 99 and returns to 0 on the clock after it shows 99, so a line lasts 100 cells.
- R3: hsync is active (low) exactly while col is 82 to 93 inclusive: 12 cells of sync, 2 cells of front porch after the visible area and 6 cells of back porch.
- R4: line rises by one on the same clock where col changes from 81 to 82, and it is stable at every other clock. After 524 it returns to 0, so a frame lasts 525 lines (52,500 cells).
- R5: The line number runs without a gap across the phase boundaries: 255 is followed by 256, 479 by 480, and 524 by 0.
- R6: Starting with the second line after reset, de is high exactly when col is below 80 and line is below 480.
- R7: vsync is active (low) exactly while line is 490 or 491.
- R8: Every full frame has 38,400 cells with de high (80 x 480) and 200 cells with vsync active (two lines).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, one tick per 8 pixels |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | output | 1 | Horizontal sync, active low by default |
| vsync | output | 1 | Vertical sync, active low by default |
| de | output | 1 | High when the current cell is inside the 640x480 picture |
| col | output | 7 | Current cell column, 0 to 99 |
| line | output | 10 | Current scanline, 0 to 524 |

## Verification
A wrong horizontal count or a wrong early-wrap flag shows within one line: col skips or repeats a value, or the 12-cell hsync window moves. A wrong vertical count or phase does not show until a phase boundary. It then appears as a jump in line at 255, 479 or 524, as de staying on into blanking, or as vsync landing on the wrong two lines. So the bench compares every cell of more than two frames against an independent position model. It also counts de and vsync cells over one full frame.

// File: rtl/vtt_pkg.sv
package vtt_pkg;
   // Which stretch of the frame the vertical counter is covering
   typedef enum logic [1:0] {
      PH_LOW   = 2'd0,   // lines 0 .. 2**VCW-1, count is the line number
      PH_HIGH  = 2'd1,   // count plus 2**VCW is the line number
      PH_BLANK = 2'd2    // vertical blanking, count is offset past the visible area
   } vphase_e;
endpackage

// File: rtl/vtt_hcell.sv
module vtt_hcell #(
   parameter int H_TOTAL  = 100,
   parameter int H_VIS    = 80,
   parameter int HS_FIRST = 82,
   parameter int HS_LAST  = 93,
   localparam int HW      = $clog2(H_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_on,
   output logic [HW-1:0] col,
   output logic          hs_act,
   output logic          h_on,
   output logic          line_step
);
   localparam logic [HW-1:0] WRAP_DEC = HW'(H_TOTAL - 2);
   localparam logic [HW-1:0] LAST_COL = HW'(H_TOTAL - 1);
   localparam logic [HW-1:0] VIS_LAST = HW'(H_VIS - 1);
   localparam logic [HW-1:0] HS_DEC   = HW'(HS_FIRST - 1);
   localparam logic [HW-1:0] HS_END   = HW'(HS_LAST);

   generate
      if (H_TOTAL < 3 || H_VIS < 1 || HS_FIRST <= H_VIS || HS_LAST < HS_FIRST
          || HS_LAST >= H_TOTAL) begin : g_bad_h
         $error("vtt_hcell: horizontal timing parameters out of order");
      end
   endgenerate

   logic wrap_q;

   // the cycle before hsync turns on; the vertical side steps at that edge
   assign line_step = (col == HS_DEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col    <= '0;
         wrap_q <= 1'b0;
         hs_act <= 1'b0;
         h_on   <= 1'b0;
      end else begin
         wrap_q <= (col == WRAP_DEC);
         col    <= wrap_q ? '0 : col + 1'b1;

         if (col == HS_DEC)
            hs_act <= 1'b1;
         else if (col == HS_END)
            hs_act <= 1'b0;

         if (col == LAST_COL)
            h_on <= v_on;
         else if (col == VIS_LAST)
            h_on <= 1'b0;
      end
   end
endmodule

// File: rtl/vtt_vline.sv
module vtt_vline
   import vtt_pkg::*;
#(
   parameter int VCW      = 8,
   parameter int P2_LAST  = 223,
   parameter int P3_LAST  = 44,
   parameter int VS_FIRST = 10,
   parameter int VS_LAST  = 11,
   localparam int V_VIS   = (1 << VCW) + P2_LAST + 1,
   localparam int V_TOTAL = V_VIS + P3_LAST + 1,
   localparam int LW      = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [LW-1:0] line,
   output logic          v_on,
   output logic          vs_act
);
   localparam logic [VCW-1:0] CNT_MAX = '1;
   localparam logic [VCW-1:0] P2_END  = VCW'(P2_LAST);
   localparam logic [VCW-1:0] P2_DEC  = VCW'(P2_LAST - 1);
   localparam logic [VCW-1:0] P3_END  = VCW'(P3_LAST);
   localparam logic [VCW-1:0] P3_DEC  = VCW'(P3_LAST - 1);
   localparam logic [VCW-1:0] VS_DEC0 = VCW'(VS_FIRST - 1);
   localparam logic [VCW-1:0] VS_DEC1 = VCW'(VS_LAST - 1);

   generate
      if (P2_LAST < 1 || P2_LAST >= (1 << VCW) || P3_LAST < 1 || P3_LAST >= (1 << VCW)
          || VS_FIRST < 1 || VS_LAST < VS_FIRST || VS_LAST > P3_LAST) begin : g_bad_v
         $error("vtt_vline: vertical timing parameters out of range");
      end
   endgenerate

   logic [VCW-1:0] vcnt;
   vphase_e        phase;
   logic           vrst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vcnt   <= '0;
         phase  <= PH_LOW;
         vrst_q <= 1'b0;
         vs_act <= 1'b0;
      end else if (step) begin
         vrst_q <= (phase == PH_HIGH  && vcnt == P2_DEC) ||
                   (phase == PH_BLANK && vcnt == P3_DEC);
         vcnt   <= vrst_q ? '0 : vcnt + 1'b1;
         vs_act <= (phase == PH_BLANK) && (vcnt >= VS_DEC0) && (vcnt <= VS_DEC1);
         unique case (phase)
            PH_LOW:   if (vcnt == CNT_MAX) phase <= PH_HIGH;
            PH_HIGH:  if (vcnt == P2_END)  phase <= PH_BLANK;
            PH_BLANK: if (vcnt == P3_END)  phase <= PH_LOW;
            default:  phase <= PH_LOW;
         endcase
      end
   end

   assign v_on = (phase != PH_BLANK);

   always_comb begin
      unique case (phase)
         PH_HIGH:  line = LW'(1 << VCW) + LW'(vcnt);
         PH_BLANK: line = LW'(V_VIS) + LW'(vcnt);
         default:  line = LW'(vcnt);
      endcase
   end
endmodule

// File: rtl/vga_text_timing.sv
module vga_text_timing #(
   parameter int H_TOTAL    = 100,
   parameter int H_VIS      = 80,
   parameter int HS_FIRST   = 82,
   parameter int HS_LAST    = 93,
   parameter int VCW        = 8,
   parameter int P2_LAST    = 223,
   parameter int P3_LAST    = 44,
   parameter int VS_FIRST   = 10,
   parameter int VS_LAST    = 11,
   parameter bit SYNC_LOW   = 1'b1,
   localparam int HW        = $clog2(H_TOTAL),
   localparam int V_TOTAL   = (1 << VCW) + P2_LAST + 1 + P3_LAST + 1,
   localparam int LW        = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [HW-1:0] col,
   output logic [LW-1:0] line
);
   logic hs_act, vs_act, h_on, v_on, line_step;

   vtt_hcell #(
      .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .HS_FIRST(HS_FIRST), .HS_LAST(HS_LAST)
   ) u_h (
      .clk(clk), .rst_n(rst_n), .v_on(v_on), .col(col),
      .hs_act(hs_act), .h_on(h_on), .line_step(line_step)
   );

   vtt_vline #(
      .VCW(VCW), .P2_LAST(P2_LAST), .P3_LAST(P3_LAST),
      .VS_FIRST(VS_FIRST), .VS_LAST(VS_LAST)
   ) u_v (
      .clk(clk), .rst_n(rst_n), .step(line_step),
      .line(line), .v_on(v_on), .vs_act(vs_act)
   );

   assign de = h_on;

   generate
      if (SYNC_LOW) begin : g_sync_low
         assign hsync = ~hs_act;
         assign vsync = ~vs_act;
      end else begin : g_sync_high
         assign hsync = hs_act;
         assign vsync = vs_act;
      end
   endgenerate
endmodule

// File: rtl/vga_text_timing_chk.sv
module vga_text_timing_chk #(
   parameter int H_TOTAL  = 100,
   parameter int H_VIS    = 80,
   parameter int HS_FIRST = 82,
   parameter int HS_LAST  = 93,
   parameter int V_VIS    = 480,
   parameter int VS_L0    = 490,
   parameter int VS_L1    = 491,
   parameter bit SYNC_LOW = 1'b1,
   parameter int HW       = 7,
   parameter int LW       = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hsync,
   input logic          vsync,
   input logic          de,
   input logic [HW-1:0] col,
   input logic [LW-1:0] line
);
   logic hs_on, vs_on;
   assign hs_on = (hsync != SYNC_LOW);
   assign vs_on = (vsync != SYNC_LOW);

   // R2
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(col) != H_TOTAL - 1) |=> (int'(col) == int'($past(col)) + 1));

   // R2
   col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(col) == H_TOTAL - 1) |=> (col == '0));

   // R3
   hsync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_on |-> (int'(col) >= HS_FIRST && int'(col) <= HS_LAST));

   // R4
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line) |-> (int'(col) == HS_FIRST));

   // R6
   de_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (int'(col) < H_VIS && int'(line) < V_VIS));

   // R7
   vsync_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vs_on |-> (int'(line) == VS_L0 || int'(line) == VS_L1));
endmodule

bind vga_text_timing vga_text_timing_chk #(
   .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .HS_FIRST(HS_FIRST), .HS_LAST(HS_LAST),
   .V_VIS((1 << VCW) + P2_LAST + 1),
   .VS_L0((1 << VCW) + P2_LAST + 1 + VS_FIRST),
   .VS_L1((1 << VCW) + P2_LAST + 1 + VS_LAST),
   .SYNC_LOW(SYNC_LOW), .HW(HW), .LW(LW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
   .de(de), .col(col), .line(line)
);

// File: tb/tb_vga_text_timing.sv
module tb_vga_text_timing;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync, vsync, de;
   logic [6:0] col;
   logic [9:0] line;

   int tests = 0;
   int fails = 0;
   int k     = 0;

   always #2 clk = ~clk;   // 250 MHz

   vga_text_timing dut (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .de(de), .col(col), .line(line)
   );

   typedef struct packed {
      int         kk;
      logic [6:0] c;
      logic [9:0] l;
      logic       hs;
      logic       vs;
      logic       en;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{0,     7'd0,  10'd0,   1'b1, 1'b1, 1'b0},
      '{81,    7'd81, 10'd0,   1'b1, 1'b1, 1'b0},
      '{82,    7'd82, 10'd1,   1'b0, 1'b1, 1'b0},
      '{93,    7'd93, 10'd1,   1'b0, 1'b1, 1'b0},
      '{94,    7'd94, 10'd1,   1'b1, 1'b1, 1'b0},
      '{99,    7'd99, 10'd1,   1'b1, 1'b1, 1'b0},
      '{100,   7'd0,  10'd1,   1'b1, 1'b1, 1'b1},
      '{179,   7'd79, 10'd1,   1'b1, 1'b1, 1'b1},
      '{180,   7'd80, 10'd1,   1'b1, 1'b1, 1'b0},
      '{25581, 7'd81, 10'd255, 1'b1, 1'b1, 1'b0},
      '{25582, 7'd82, 10'd256, 1'b0, 1'b1, 1'b0},
      '{25600, 7'd0,  10'd256, 1'b1, 1'b1, 1'b1},
      '{47979, 7'd79, 10'd479, 1'b1, 1'b1, 1'b1},
      '{47982, 7'd82, 10'd480, 1'b0, 1'b1, 1'b0},
      '{48000, 7'd0,  10'd480, 1'b1, 1'b1, 1'b0},
      '{48981, 7'd81, 10'd489, 1'b1, 1'b1, 1'b0},
      '{48982, 7'd82, 10'd490, 1'b0, 1'b0, 1'b0},
      '{49181, 7'd81, 10'd491, 1'b1, 1'b0, 1'b0},
      '{49182, 7'd82, 10'd492, 1'b0, 1'b1, 1'b0},
      '{52481, 7'd81, 10'd524, 1'b1, 1'b1, 1'b0},
      '{52482, 7'd82, 10'd0,   1'b0, 1'b1, 1'b0},
      '{52500, 7'd0,  10'd0,   1'b1, 1'b1, 1'b1}
   };

   // independent position model, from the requirements
   function automatic void model(input int t, output int mc, output int ml,
                                 output logic mhs, output logic mvs, output logic mde);
      mc  = t % 100;
      ml  = (t < 82) ? 0 : (((t - 82) / 100) + 1) % 525;
      mhs = !(mc >= 82 && mc <= 93);
      mvs = !(ml == 490 || ml == 491);
      mde = (t >= 100) && (mc < 80) && (ml < 480);
   endfunction

   task automatic check_model();
      int mc, ml;
      logic mhs, mvs, mde;
      model(k, mc, ml, mhs, mvs, mde);
      tests++;
      if (int'(col) != mc || int'(line) != ml || hsync != mhs || vsync != mvs || de != mde) begin
         fails++;
         if (int'(col) != mc)
            $display("FAIL R2 k=%0d col actual %0d expected %0d", k, col, mc);
         if (int'(line) != ml)
            $display("FAIL R4 k=%0d line actual %0d expected %0d", k, line, ml);
         if (hsync != mhs)
            $display("FAIL R3 k=%0d hsync actual %0b expected %0b", k, hsync, mhs);
         if (vsync != mvs)
            $display("FAIL R7 k=%0d vsync actual %0b expected %0b", k, vsync, mvs);
         if (de != mde)
            $display("FAIL R6 k=%0d de actual %0b expected %0b", k, de, mde);
      end
   endtask

   int de_cnt = 0;
   int vs_cnt = 0;

   task automatic step();
      @(posedge clk);
      k++;
      @(negedge clk);
      check_model();
      if (k >= 52500 && k < 105000) begin
         if (de) de_cnt++;
         if (!vsync) vs_cnt++;
      end
   endtask

   task automatic check_reset(input string tag);
      tests++;
      if (col != 7'd0 || line != 10'd0 || de != 1'b0 || hsync != 1'b1 || vsync != 1'b1) begin
         fails++;
         $display("FAIL R1 %s col=%0d line=%0d de=%0b hs=%0b vs=%0b expected 0 0 0 1 1",
                  tag, col, line, de, hsync, vsync);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset("during reset");
      rst_n = 1'b1;
      k = 0;
      check_model();

      // table walk: R5 phase boundaries plus R2/R3/R4/R6/R7 points
      for (int i = 0; i < NV; i++) begin
         while (k < VEC[i].kk) step();
         tests++;
         if (col != VEC[i].c || line != VEC[i].l || hsync != VEC[i].hs ||
             vsync != VEC[i].vs || de != VEC[i].en) begin
            fails++;
            $display("FAIL R5 vec %0d k=%0d actual c=%0d l=%0d hs=%0b vs=%0b de=%0b expected c=%0d l=%0d hs=%0b vs=%0b de=%0b",
                     i, k, col, line, hsync, vsync, de,
                     VEC[i].c, VEC[i].l, VEC[i].hs, VEC[i].vs, VEC[i].en);
         end
      end

      while (k < 105100) step();

      // R8 whole-frame totals
      tests++;
      if (de_cnt != 38400) begin
         fails++;
         $display("FAIL R8 de cells actual %0d expected 38400", de_cnt);
      end
      tests++;
      if (vs_cnt != 200) begin
         fails++;
         $display("FAIL R8 vsync cells actual %0d expected 200", vs_cnt);
      end

      // R1 reset in mid-frame
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_reset("mid-frame");
      rst_n = 1'b1;
      k = 0;
      check_model();
      tests++;
      if (de != 1'b0 || col != 7'd0) begin
         fails++;
         $display("FAIL R1 first cycle after release de=%0b col=%0d expected 0 0", de, col);
      end
      while (k < 300) step();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1000000;
      $display("FAIL watchdog expired at k=%0d", k);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
   end
endmodule